// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block collects message-signalled interrupts. An inbound write to a programmable 64-bit doorbell address carries a vector number in its 32-bit data word. The block records that vector as a pending bit in a 32-bit status register and drives a single level-sensitive interrupt line toward the host. Software programs the doorbell address, a per-vector enable register and a per-vector mask register over a plain 32-bit register port. It acknowledges vectors by writing ones to the status register, which toggles those bits.

The enable register has two jobs. Each bit gates its own vector. When the whole register is zero, the doorbell window does not decode at all. The interrupt line rises when a doorbell leaves any unmasked bit pending. It falls only when a status write leaves the status register at exactly zero. Masking a pending bit afterwards does not lower the line.

The inbound port is a valid/ready stream. `db_ready` is held high, so every beat with `db_valid` high is taken in its own cycle and the block never applies back-pressure. A beat with `db_we` low is a read of the window.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: An accepted doorbell write whose data value v is below 32 sets status bit v one clock later, provided enable bit v is set. Bits already pending are kept.
- R2: A doorbell write leaves the status unchanged in two cases: its data value is 32 or more, or the enable bit it names is clear.
- R3: A register write to the status register (word index 2) XORs the written value into the status. Writing a one clears a pending bit and sets a clear bit.
- R4: After an accepted doorbell write, `irq` is high on the following clock if any status bit is set whose mask bit is clear. A doorbell that leaves only masked bits pending does not raise `irq`.
- R5: `irq` falls only on the clock after a status-register write that leaves the status at exactly zero. A nonzero status keeps `irq` high, even when every pending bit is masked or gets masked later.
- R6: The doorbell base is written as a low half (word index 3) and a high half (word index 4). Each write replaces only its own half. Enable (index 0), mask (index 1), status (index 2) and both base halves read back their current values on `reg_rdata`, combinationally from `reg_addr`.
- R7: A doorbell write is decoded only while the enable register is nonzero and `db_addr` equals the programmed 64-bit base. Any other address has no effect.
- R8: A doorbell beat with `db_we` low returns zero on `db_rdata` and changes no state.
- R9: A doorbell write with `db_be` other than 4'hF (a narrower access) is ignored.
- R10: Reset clears base, enable, mask and status to zero and holds `irq` low.
- R11: When a doorbell write and a status-register write fall in the same cycle, the XOR is applied first and the doorbell bit is ORed in after it. The `irq` update uses that combined result.
- R12: `db_ready` is always high, so every valid doorbell beat is taken in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| db_valid | input | 1 | Inbound doorbell beat valid |
| db_ready | output | 1 | Inbound doorbell ready (always 1) |
| db_we | input | 1 | Beat is a write (1) or a read (0) |
| db_addr | input | 64 | Inbound byte address |
| db_be | input | 4 | Inbound byte enables, little-endian |
| db_wdata | input | 32 | Inbound data word (vector number) |
| db_rdata | output | 32 | Inbound read data (always zero) |
| irq | output | 1 | Level interrupt toward the host |

## Verification
Doorbells are sent with vector values that are enabled, disabled and out of range. This tells the per-bit enable gate apart from the range check. Doorbells also go to a neighbouring address, use partial byte enables, arrive as reads and arrive while the enable register is zero, which separates each cause of rejection from the address compare. Status writes toggle bits in three situations: a partial clear, clearing every remaining bit, and setting a clear bit. Together with masks applied before and after a vector is pending, this shows that the line falls only on an exactly-zero status. Two cases run a status write and a doorbell in the same cycle; one ends with a nonzero status and one with zero, which fixes the order in which the two updates are applied.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RIDX_ENABLE  = 3'd0,
    RIDX_MASK    = 3'd1,
    RIDX_STATUS  = 3'd2,
    RIDX_BASE_LO = 3'd3,
    RIDX_BASE_HI = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                db_valid,
  input  logic                db_we,
  input  logic [ADDR_W-1:0]   db_addr,
  input  logic [DATA_W/8-1:0] db_be,
  input  logic [DATA_W-1:0]   db_wdata,
  input  logic [ADDR_W-1:0]   base_q,
  input  logic [NUM_VEC-1:0]  enable_q,
  output logic                hit,
  output logic [NUM_VEC-1:0]  vec_sel
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic full_word;
  logic window_open;

  assign full_word   = (db_be == {BE_W{1'b1}});
  assign window_open = |enable_q;
  assign hit = db_valid && db_we && full_word && window_open && (db_addr == base_q);

  // One compare per vector: values at or above NUM_VEC match nothing.
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
    assign vec_sel[gi] = (db_wdata == DATA_W'(gi));
  end
endmodule

// File: rtl/msi_db_regs.sv
module msi_db_regs
  import msi_db_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 db_hit,
  input  logic [NUM_VEC-1:0]   db_vec,
  output logic [ADDR_W-1:0]    base_q,
  output logic [NUM_VEC-1:0]   enable_q,
  output logic [NUM_VEC-1:0]   mask_q,
  output logic [NUM_VEC-1:0]   status_q,
  output logic [NUM_VEC-1:0]   status_d,
  output logic                 sts_wr
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [NUM_VEC-1:0] after_wr;
  logic [NUM_VEC-1:0] db_bits;

  assign sts_wr   = reg_we && (reg_addr == RIDX_STATUS);
  assign after_wr = sts_wr ? (status_q ^ reg_wdata[NUM_VEC-1:0]) : status_q;
  assign db_bits  = db_hit ? (db_vec & enable_q) : '0;
  assign status_d = after_wr | db_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      enable_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      status_q <= status_d;
      if (reg_we) begin
        case (reg_addr)
          RIDX_ENABLE:  enable_q <= reg_wdata[NUM_VEC-1:0];
          RIDX_MASK:    mask_q   <= reg_wdata[NUM_VEC-1:0];
          RIDX_BASE_LO: base_q[DATA_W-1:0] <= reg_wdata;
          RIDX_BASE_HI: base_q[ADDR_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RIDX_ENABLE:  reg_rdata = DATA_W'(enable_q);
      RIDX_MASK:    reg_rdata = DATA_W'(mask_q);
      RIDX_STATUS:  reg_rdata = DATA_W'(status_q);
      RIDX_BASE_LO: reg_rdata = base_q[DATA_W-1:0];
      RIDX_BASE_HI: reg_rdata = DATA_W'(base_q[ADDR_W-1:DATA_W]);
      default:      reg_rdata = '0;
    endcase
  end

  // R1 / R2: without a status write, at most one bit can appear per clock, and only an enabled one
  a_r1_single_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_wr) |-> ($countones(status_q & ~$past(status_q)) <= 1));
  a_r2_new_bits_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_wr) |-> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));
  // R3: without a doorbell, a status write changes status by exactly the written value
  a_r3_xor_update: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_wr) && !$past(db_hit)) |-> ((status_q ^ $past(status_q)) == $past(reg_wdata[NUM_VEC-1:0])));
endmodule

// File: rtl/msi_db_irq.sv
module msi_db_irq #(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               db_hit,
  input  logic               sts_wr,
  input  logic [NUM_VEC-1:0] status_d,
  input  logic [NUM_VEC-1:0] status_q,
  input  logic [NUM_VEC-1:0] mask_q,
  output logic               irq_q
);
  logic set_req;
  logic clr_req;

  assign set_req = db_hit && |(status_d & ~mask_q);
  assign clr_req = sts_wr && (status_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (set_req) irq_q <= 1'b1;
    else if (clr_req) irq_q <= 1'b0;
  end

  // R5: the line only falls when a status write has just left status at zero
  a_r5_fall_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ($past(sts_wr) && (status_q == '0)));
  // R4: the line only rises after a doorbell
  a_r4_rise_after_db: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(db_hit));
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_db_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 db_valid,
  output logic                 db_ready,
  input  logic                 db_we,
  input  logic [ADDR_W-1:0]    db_addr,
  input  logic [DATA_W/8-1:0]  db_be,
  input  logic [DATA_W-1:0]    db_wdata,
  output logic [DATA_W-1:0]    db_rdata,
  output logic                 irq
);
  logic               hit;
  logic [NUM_VEC-1:0] vec_sel;
  logic [ADDR_W-1:0]  base_q;
  logic [NUM_VEC-1:0] enable_q, mask_q, status_q, status_d;
  logic               sts_wr;

  assign db_ready = 1'b1;
  assign db_rdata = '0;

  msi_db_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_decode (
    .db_valid(db_valid), .db_we(db_we), .db_addr(db_addr), .db_be(db_be),
    .db_wdata(db_wdata), .base_q(base_q), .enable_q(enable_q),
    .hit(hit), .vec_sel(vec_sel)
  );

  msi_db_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_hit(hit), .db_vec(vec_sel),
    .base_q(base_q), .enable_q(enable_q), .mask_q(mask_q), .status_q(status_q),
    .status_d(status_d), .sts_wr(sts_wr)
  );

  msi_db_irq #(.NUM_VEC(NUM_VEC)) u_irq (
    .clk(clk), .rst_n(rst_n), .db_hit(hit), .sts_wr(sts_wr), .status_d(status_d),
    .status_q(status_q), .mask_q(mask_q), .irq_q(irq)
  );

  // R7 / R8 / R9: status changes only after a decoded doorbell or a status write
  a_r7_status_source: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != $past(status_q)) |-> ($past(hit) || $past(sts_wr)));
  // R7: a decoded doorbell implies the window was open and the address matched
  a_r7_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((enable_q != '0) && (db_addr == base_q) && db_we));
  // R12: the inbound stream never stalls
  a_r12_always_ready: assert property (@(posedge clk) disable iff (!rst_n) db_ready);
endmodule

// File: tb/tb_msi_doorbell_ctrl.sv
module tb_msi_doorbell_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        db_valid = 1'b0;
  logic        db_ready;
  logic        db_we = 1'b0;
  logic [63:0] db_addr = '0;
  logic [3:0]  db_be = '0;
  logic [31:0] db_wdata = '0;
  logic [31:0] db_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  // reference model state
  logic [63:0] m_base = '0;
  logic [31:0] m_en = '0, m_mask = '0, m_sts = '0;
  logic        m_irq = 1'b0;

  typedef struct packed {
    logic [31:0] rd;
    logic        irq;
    logic [7:0]  req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  msi_doorbell_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
    .db_ready(db_ready), .db_we(db_we), .db_addr(db_addr), .db_be(db_be),
    .db_wdata(db_wdata), .db_rdata(db_rdata), .irq(irq)
  );

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_checks++;
      if (reg_rdata !== e.rd || irq !== e.irq) begin
        n_errors++;
        $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.req, reg_rdata, irq, e.rd, e.irq);
      end
    end
  end

  function automatic logic [31:0] model_reg(input int idx);
    case (idx)
      0: return m_en;
      1: return m_mask;
      2: return m_sts;
      3: return m_base[31:0];
      4: return m_base[63:32];
      default: return '0;
    endcase
  endfunction

  task automatic idle_inputs();
    reg_we = 1'b0; db_valid = 1'b0; db_we = 1'b0; db_be = '0;
  endtask

  // one clock carrying an optional register write and an optional doorbell beat
  task automatic step(input logic rw, input int ridx, input logic [31:0] rval,
                      input logic dv, input logic dwe, input logic [63:0] da,
                      input logic [3:0] dbe, input logic [31:0] dd);
    logic [31:0] nxt;
    logic hit;
    @(negedge clk);
    idle_inputs();
    reg_we = rw; reg_addr = 3'(ridx); reg_wdata = rval;
    db_valid = dv; db_we = dwe; db_addr = da; db_be = dbe; db_wdata = dd;
    hit = dv && dwe && dbe == 4'hF && m_en != 0 && da == m_base;
    nxt = m_sts;
    if (rw && ridx == 2) nxt = nxt ^ rval;
    if (hit && dd < 32) nxt = nxt | ((32'd1 << dd[4:0]) & m_en);
    if (hit && (nxt & ~m_mask) != 0) m_irq = 1'b1;
    else if (rw && ridx == 2 && nxt == 0) m_irq = 1'b0;
    m_sts = nxt;
    if (rw) begin
      case (ridx)
        0: m_en = rval;
        1: m_mask = rval;
        3: m_base[31:0] = rval;
        4: m_base[63:32] = rval;
        default: ;
      endcase
    end
  endtask

  task automatic rw(input int idx, input logic [31:0] v);
    step(1'b1, idx, v, 1'b0, 1'b0, '0, 4'h0, '0);
  endtask

  task automatic ring(input logic [63:0] a, input logic [31:0] v);
    step(1'b0, 0, '0, 1'b1, 1'b1, a, 4'hF, v);
  endtask

  // push an expected readback of register idx plus irq level
  task automatic chk(input int idx, input int req);
    @(negedge clk);
    idle_inputs();
    reg_addr = 3'(idx);
    sb.push_back('{rd: model_reg(idx), irq: m_irq, req: 8'(req)});
  endtask

  task automatic chk_direct(input logic ok, input int req, input logic [31:0] act, input logic [31:0] ex);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, ex);
    end
  endtask

  initial begin
    #200000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    for (int i = 0; i < 5; i++) chk(i, 10);
    // R6: base halves, each write replaces its own half
    rw(3, 32'h1000_0040); rw(4, 32'h0000_0002);
    chk(3, 6); chk(4, 6);
    rw(3, 32'h2000_0080); chk(3, 6); chk(4, 6);
    b = m_base;
    // R7: window closed while enable is zero
    ring(b, 3); chk(2, 7);
    // R6 readback of enable; R1 / R4 first vector
    rw(0, 32'hFFFF_00FF); chk(0, 6);
    ring(b, 3); chk(2, 1);
    // R2: disabled vector and out-of-range value
    ring(b, 9); chk(2, 2);
    ring(b, 40); chk(2, 2);
    ring(b, 0); chk(2, 1);
    // R7 wrong address; R9 partial access; R8 read beat
    ring(b + 64'd4, 1); chk(2, 7);
    step(1'b0, 0, '0, 1'b1, 1'b1, b, 4'h7, 32'd2); chk(2, 9);
    step(1'b0, 0, '0, 1'b1, 1'b0, b, 4'hF, 32'd2);
    #2 chk_direct(db_rdata == 0, 8, db_rdata, 0);
    chk(2, 8);
    // R3 / R5: partial clear keeps irq, masking keeps irq, zero drops it
    rw(2, 32'h1); chk(2, 3);
    rw(1, 32'h8); chk(1, 5);
    rw(2, 32'h8); chk(2, 5);
    // R4: masked-only doorbell does not raise irq, unmasked does
    ring(b, 3); chk(2, 4);
    ring(b, 1); chk(2, 4);
    // R5: masked nonzero status keeps irq high
    rw(2, 32'h2); chk(2, 5);
    rw(2, 32'h8); chk(2, 5);
    // R3: writing a one to a clear bit sets it
    rw(2, 32'h4); chk(2, 3);
    rw(2, 32'h4); chk(2, 3);
    // R11: same-cycle status write and doorbell
    rw(1, 32'h0);
    ring(b, 5); chk(2, 11);
    step(1'b1, 2, 32'h20, 1'b1, 1'b1, b, 4'hF, 32'd5); chk(2, 11);
    step(1'b1, 2, 32'h20, 1'b1, 1'b1, b, 4'hF, 32'd9); chk(2, 11);
    // R12: ready always high
    @(negedge clk);
    chk_direct(db_ready == 1'b1, 12, 32'(db_ready), 1);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule